// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a clocked request port to an external asynchronous static RAM with 16-bit words and an 18-bit word address. A client offers one access at a time: a read/write flag, an address, write data and two byte-lane enables, qualified by a valid/ready handshake. The controller latches the request, drives the memory's active-low select, output-enable, write-strobe and per-lane enables, and sequences the access through fixed phases. For reads it returns the data with a one-cycle valid strobe.

Each phase lasts a whole number of clock cycles. That number is derived at elaboration from the clock period and the memory's nanosecond minimums. The controller rounds up and never allows a phase shorter than one cycle. The data bus is split into an output value, a drive enable and an input value, so that the pad ring outside this block can build the bidirectional pin. Between accesses the memory is left deselected, which is its low-power standby state.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset and whenever idle, `req_ready` is 1, `sram_ce_n`, `sram_oe_n`, `sram_we_n`, `sram_lb_n` and `sram_ub_n` are all 1, and `sram_dq_oe` is 0.
- R2: During a write, `sram_we_n` is low for exactly PUL = max(ceil(T_WP/T), ceil(T_DS/T)) cycles, only while `sram_ce_n` is low and `sram_oe_n` is high. `sram_dq_oe` is 1 and `sram_dq_out` holds the accepted write data for the whole time chip enable is low, including at least one cycle after the strobe rises.
- R3: A write keeps `sram_ce_n` low for 1 + PUL + max(1, ceil(T_WC/T) - 1 - PUL) cycles (4 cycles at the default 5 ns clock).
- R4: Request bit `be[0]` controls data bits 7..0 through `sram_lb_n`, and `be[1]` controls bits 15..8 through `sram_ub_n`. A lane's enable is low for the whole access exactly when its bit is 1. A write leaves the memory contents of a disabled lane unchanged.
- R5: A read holds `sram_we_n` high and `sram_oe_n` low for exactly ACC = max(ceil(T_AA/T), ceil(T_OE/T)) cycles. `sram_oe_n` falls only after at least one cycle with chip enable low and `sram_dq_oe` already 0. `sram_dq_oe` and a low `sram_oe_n` never occur together.
- R6: Read data is sampled on the last output-enable-low cycle. `rsp_valid` is high for exactly one cycle, 1 + ACC cycles after the accepting edge, and it is never raised for a write.
- R7: In `rsp_data`, the bits of a lane whose request enable was 0 read as zero. Enabled lanes carry the memory word.
- R8: After `sram_oe_n` rises, the controller waits ceil(T_HZ/T) cycles with the bus undriven before `req_ready` returns. `sram_dq_oe` stays 0 for at least that many cycles.
- R9: A request is taken only on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the access ends. Request inputs that change after acceptance have no effect on the access in progress.
- R10: While `sram_ce_n` is low, `sram_addr` equals the accepted address and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_lb_n | output | 1 | Low-lane enable, active low |
| sram_ub_n | output | 1 | High-lane enable, active low |
| sram_dq_out | output | 16 | Data driven towards memory |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_in | input | 16 | Data returned from memory |

## Verification
The bench attaches a behavioural memory model. The model returns garbage on disabled lanes, and also on any lane read before the access time has elapsed. It stores data when the write strobe or chip select rises.

The bench first fills sixteen scattered addresses with full-word writes. It then overwrites them under all four lane-enable combinations and reads each back in full and through a different lane mask. The full readback separates a correct lane decode from a swapped or merged one. The masked readback separates zeroing of disabled lanes from passing through whatever the memory drives.

Write-then-read and read-then-write pairs on the same address exercise bus turnaround. A cycle-level monitor measures strobe widths, select lengths, address stability and drive overlap against the phase formulas.

// File: rtl/sramc_pkg.sv
`timescale 1ns/1ps
package sramc_pkg;

    localparam int unsigned SRAM_AW = 18;
    localparam int unsigned SRAM_DW = 16;
    localparam int unsigned LANE_W  = 8;
    localparam int unsigned LANES   = SRAM_DW / LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSET,
        ST_WPUL,
        ST_WREC,
        ST_RTRN,
        ST_RACC,
        ST_RREL
    } sramc_state_e;

    // Captured request fields carried through the datapath
    typedef struct packed {
        logic [SRAM_AW-1:0] addr;
        logic [SRAM_DW-1:0] wdata;
        logic [LANES-1:0]   be;
    } sramc_req_t;

    // Memory-side controls decoded from the sequencer state
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic lanes_on;
        logic dq_drive;
    } sramc_ctrl_t;

    // Whole cycles covering a nanosecond minimum, never below one
    function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
        int unsigned r;
        r = (ns + clk_ns - 1) / clk_ns;
        return (r == 0) ? 1 : r;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
`timescale 1ns/1ps
module sramc_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sramc_sequencer.sv
`timescale 1ns/1ps
module sramc_sequencer
    import sramc_pkg::*;
#(
    parameter int unsigned WSET_CYC = 1,
    parameter int unsigned WPUL_CYC = 2,
    parameter int unsigned WREC_CYC = 1,
    parameter int unsigned RTRN_CYC = 1,
    parameter int unsigned RACC_CYC = 3,
    parameter int unsigned RREL_CYC = 2,
    parameter int unsigned CNT_W    = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fire,
    input  logic        req_we,
    output sramc_ctrl_t ctrl,
    output logic        capture,
    output logic        ready
);
    sramc_state_e state, nxt;
    int unsigned  len_nxt;
    logic         done;
    logic         load;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (fire) nxt = req_we ? ST_WSET : ST_RTRN;
            ST_WSET: if (done) nxt = ST_WPUL;
            ST_WPUL: if (done) nxt = ST_WREC;
            ST_WREC: if (done) nxt = ST_IDLE;
            ST_RTRN: if (done) nxt = ST_RACC;
            ST_RACC: if (done) nxt = ST_RREL;
            ST_RREL: if (done) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        unique case (nxt)
            ST_WSET: len_nxt = WSET_CYC;
            ST_WPUL: len_nxt = WPUL_CYC;
            ST_WREC: len_nxt = WREC_CYC;
            ST_RTRN: len_nxt = RTRN_CYC;
            ST_RACC: len_nxt = RACC_CYC;
            ST_RREL: len_nxt = RREL_CYC;
            default: len_nxt = 1;
        endcase
    end

    assign load = (nxt != state);

    sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (CNT_W'(len_nxt - 1)),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        ctrl.ce_n     = (state == ST_IDLE);
        ctrl.oe_n     = (state != ST_RACC);
        ctrl.we_n     = (state != ST_WPUL);
        ctrl.lanes_on = (state != ST_IDLE);
        ctrl.dq_drive = (state == ST_WSET) || (state == ST_WPUL) || (state == ST_WREC);
    end

    assign capture = (state == ST_RACC) && done;
    assign ready   = (state == ST_IDLE);
endmodule

// File: rtl/sramc_datapath.sv
`timescale 1ns/1ps
module sramc_datapath
    import sramc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  sramc_req_t         req_in,
    input  sramc_ctrl_t        ctrl,
    input  logic               capture,
    input  logic [SRAM_DW-1:0] dq_in,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic [LANES-1:0]   be_n,
    output logic [SRAM_DW-1:0] dq_out,
    output logic               dq_oe,
    output logic               rsp_valid,
    output logic [SRAM_DW-1:0] rsp_data
);
    sramc_req_t         held;
    logic [SRAM_DW-1:0] lane_mask;

    always_ff @(posedge clk) begin
        if (rst)       held <= '0;
        else if (fire) held <= req_in;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{held.be[l]}};
        assign be_n[l] = !(ctrl.lanes_on && held.be[l]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture) rsp_data <= dq_in & lane_mask;
        end
    end

    assign sram_addr = held.addr;
    assign dq_out    = held.wdata;
    assign dq_oe     = ctrl.dq_drive;
endmodule

// File: rtl/sram_bus_ctrl.sv
`timescale 1ns/1ps
module sram_bus_ctrl
    import sramc_pkg::*;
#(
    parameter int unsigned CLK_NS  = 5,
    parameter int unsigned T_WP_NS = 10,
    parameter int unsigned T_DS_NS = 7,
    parameter int unsigned T_WC_NS = 12,
    parameter int unsigned T_AA_NS = 12,
    parameter int unsigned T_OE_NS = 6,
    parameter int unsigned T_HZ_NS = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_we,
    input  logic [SRAM_AW-1:0] req_addr,
    input  logic [SRAM_DW-1:0] req_wdata,
    input  logic [LANES-1:0]   req_be,
    output logic               rsp_valid,
    output logic [SRAM_DW-1:0] rsp_data,
    output logic [SRAM_AW-1:0] sram_addr,
    output logic               sram_ce_n,
    output logic               sram_oe_n,
    output logic               sram_we_n,
    output logic               sram_lb_n,
    output logic               sram_ub_n,
    output logic [SRAM_DW-1:0] sram_dq_out,
    output logic               sram_dq_oe,
    input  logic [SRAM_DW-1:0] sram_dq_in
);
    localparam int unsigned WSET_CYC = 1;
    localparam int unsigned WPUL_CYC = umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
    localparam int unsigned WC_CYC   = ns2cyc(T_WC_NS, CLK_NS);
    localparam int unsigned WREC_CYC = (WC_CYC > WSET_CYC + WPUL_CYC) ?
                                       (WC_CYC - WSET_CYC - WPUL_CYC) : 1;
    localparam int unsigned RTRN_CYC = 1;
    localparam int unsigned RACC_CYC = umax(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS));
    localparam int unsigned RREL_CYC = ns2cyc(T_HZ_NS, CLK_NS);
    localparam int unsigned MAX_CYC  = umax(umax(WPUL_CYC, WREC_CYC), umax(RACC_CYC, RREL_CYC));
    localparam int unsigned CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    sramc_ctrl_t      ctrl;
    sramc_req_t       req_in;
    logic             fire;
    logic             capture;
    logic [LANES-1:0] be_n;

    assign fire         = req_valid && req_ready;
    assign req_in.addr  = req_addr;
    assign req_in.wdata = req_wdata;
    assign req_in.be    = req_be;

    sramc_sequencer #(
        .WSET_CYC (WSET_CYC),
        .WPUL_CYC (WPUL_CYC),
        .WREC_CYC (WREC_CYC),
        .RTRN_CYC (RTRN_CYC),
        .RACC_CYC (RACC_CYC),
        .RREL_CYC (RREL_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .req_we  (req_we),
        .ctrl    (ctrl),
        .capture (capture),
        .ready   (req_ready)
    );

    sramc_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .fire      (fire),
        .req_in    (req_in),
        .ctrl      (ctrl),
        .capture   (capture),
        .dq_in     (sram_dq_in),
        .sram_addr (sram_addr),
        .be_n      (be_n),
        .dq_out    (sram_dq_out),
        .dq_oe     (sram_dq_oe),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign sram_ce_n = ctrl.ce_n;
    assign sram_oe_n = ctrl.oe_n;
    assign sram_we_n = ctrl.we_n;
    assign sram_lb_n = be_n[0];
    assign sram_ub_n = be_n[1];
endmodule

// File: rtl/sram_bus_ctrl_chk.sv
`timescale 1ns/1ps
module sram_bus_ctrl_chk #(
    parameter int unsigned PUL_CYC = 2,
    parameter int unsigned TA_CYC  = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        ce_n,
    input logic        oe_n,
    input logic        we_n,
    input logic        dq_oe,
    input logic [15:0] dq_out,
    input logic [17:0] addr
);
    logic [7:0] we_lo_cnt;
    logic [7:0] oe_hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_lo_cnt <= '0;
            oe_hi_cnt <= 8'hFF;
        end else begin
            we_lo_cnt <= we_n ? 8'd0 : we_lo_cnt + 8'd1;
            if (!oe_n)                 oe_hi_cnt <= '0;
            else if (oe_hi_cnt != 8'hFF) oe_hi_cnt <= oe_hi_cnt + 8'd1;
        end
    end

    // R1
    standby_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ce_n && !dq_oe));

    // R2
    we_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!ce_n && oe_n));

    // R2
    we_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (we_lo_cnt == 8'(PUL_CYC)));

    // R2
    wdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> $stable(dq_out));

    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !(dq_oe && !oe_n));

    // R5
    release_before_oe_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_n) |-> ($past(!dq_oe) && $past(!ce_n)));

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> (oe_hi_cnt >= 8'(TA_CYC)));

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && $past(!ce_n)) |-> $stable(addr));
endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
    .PUL_CYC (WPUL_CYC),
    .TA_CYC  (RREL_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ce_n      (sram_ce_n),
    .oe_n      (sram_oe_n),
    .we_n      (sram_we_n),
    .dq_oe     (sram_dq_oe),
    .dq_out    (sram_dq_out),
    .addr      (sram_addr)
);

// File: tb/sram_bus_ctrl_tb.sv
`timescale 1ns/1ps
module sram_bus_ctrl_tb;
    localparam int CLK = 5;

    function automatic int cdiv(input int n, input int d);
        int r;
        r = (n + d - 1) / d;
        return (r < 1) ? 1 : r;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_PUL  = mx(cdiv(10, CLK), cdiv(7, CLK));
    localparam int E_WCYC = 1 + E_PUL + mx(1, cdiv(12, CLK) - 1 - E_PUL);
    localparam int E_ACC  = mx(cdiv(12, CLK), cdiv(6, CLK));
    localparam int E_LAT  = 1 + E_ACC;
    localparam int E_TA   = cdiv(6, CLK);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [17:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n;
    logic [15:0] sram_dq_out;
    logic        sram_dq_oe;
    logic [15:0] sram_dq_in;

    always #2.5 clk = ~clk;

    sram_bus_ctrl u_dut (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready), .req_we (req_we),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_be (req_be),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data),
        .sram_addr (sram_addr), .sram_ce_n (sram_ce_n), .sram_oe_n (sram_oe_n),
        .sram_we_n (sram_we_n), .sram_lb_n (sram_lb_n), .sram_ub_n (sram_ub_n),
        .sram_dq_out (sram_dq_out), .sram_dq_oe (sram_dq_oe), .sram_dq_in (sram_dq_in)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural memory: 256 words addressed by the low address byte
    logic [15:0] mem    [0:255];
    logic [15:0] shadow [0:255];
    int          oecnt = 0;
    wire         wr_end = sram_ce_n | sram_we_n;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 16'h0;
            shadow[i] = 16'h0;
        end
    end

    always @(posedge wr_end) begin
        if (!rst && sram_dq_oe) begin
            if (!sram_lb_n) mem[sram_addr[7:0]][7:0]  <= sram_dq_out[7:0];
            if (!sram_ub_n) mem[sram_addr[7:0]][15:8] <= sram_dq_out[15:8];
        end
    end

    always @(posedge clk) oecnt <= sram_oe_n ? 0 : oecnt + 1;

    always_comb begin
        sram_dq_in = 16'hC33C;
        if (!sram_ce_n && !sram_oe_n && sram_we_n && ((oecnt + 1) * CLK >= 12)) begin
            if (!sram_lb_n) sram_dq_in[7:0]  = mem[sram_addr[7:0]][7:0];
            if (!sram_ub_n) sram_dq_in[15:8] = mem[sram_addr[7:0]][15:8];
        end
    end

    // Expected access, set when a request is offered
    logic [17:0] exp_addr = '0;
    logic [15:0] exp_wd = '0;
    logic [1:0]  exp_be = '0;
    bit          last_wr = 1'b0;

    int ce_run = 0, we_run = 0, oe_run = 0, oe_hi = 100;
    bit prev_dq_oe = 1'b0, prev_oe_n = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (!sram_ce_n) begin
                ce_run++;
                check(sram_addr == exp_addr, "R10 address during access", 32'(sram_addr), 32'(exp_addr));
                check({sram_ub_n, sram_lb_n} == ~exp_be, "R4 lane enables", 32'({sram_ub_n, sram_lb_n}), 32'(~exp_be));
                if (sram_dq_oe)
                    check(sram_dq_out == exp_wd, "R2 write data driven", 32'(sram_dq_out), 32'(exp_wd));
            end else if (ce_run > 0) begin
                if (last_wr) check(ce_run == E_WCYC, "R3 write select length", 32'(ce_run), 32'(E_WCYC));
                ce_run = 0;
            end
            if (!sram_we_n) we_run++;
            else if (we_run > 0) begin
                check(we_run == E_PUL, "R2 strobe width", 32'(we_run), 32'(E_PUL));
                we_run = 0;
            end
            if (!sram_oe_n) oe_run++;
            else if (oe_run > 0) begin
                check(oe_run == E_ACC, "R5 output enable width", 32'(oe_run), 32'(E_ACC));
                oe_run = 0;
            end
            if (sram_dq_oe && !sram_oe_n) check(1'b0, "R5 bus contention", 32'd1, 32'd0);
            if (!sram_we_n && (sram_ce_n || !sram_oe_n)) check(1'b0, "R2 strobe without select", 32'd1, 32'd0);
            if (sram_dq_oe && !prev_dq_oe)
                check(oe_hi >= E_TA, "R8 turnaround before drive", 32'(oe_hi), 32'(E_TA));
            if (!sram_oe_n && prev_oe_n)
                check(!prev_dq_oe && !sram_dq_oe && sram_we_n, "R5 release before output enable", 32'(prev_dq_oe), 32'd0);
            if (rsp_valid && last_wr) check(1'b0, "R6 response on write", 32'd1, 32'd0);
            oe_hi = sram_oe_n ? oe_hi + 1 : 0;
            prev_dq_oe = sram_dq_oe;
            prev_oe_n = sram_oe_n;
        end
    end

    task automatic check_idle(input string when_s);
        check(req_ready && sram_ce_n && sram_oe_n && sram_we_n && sram_lb_n && sram_ub_n && !sram_dq_oe,
              {"R1 idle pins ", when_s},
              32'({req_ready, sram_ce_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n, sram_dq_oe}), 32'h7E);
    endtask

    task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
        int lat;
        int k;
        logic [15:0] m;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_addr = a; exp_wd = d; exp_be = be; last_wr = wr;
        req_valid = 1'b1; req_we = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        // R9: scramble request inputs once the access is under way
        req_valid = 1'b0; req_we = ~wr; req_addr = ~a; req_wdata = ~d; req_be = ~be;
        check(!req_ready, "R9 ready drops after acceptance", 32'(req_ready), 32'd0);
        if (wr) begin
            if (be[0]) shadow[a[7:0]][7:0]  = d[7:0];
            if (be[1]) shadow[a[7:0]][15:8] = d[15:8];
            while (!req_ready) @(negedge clk);
        end else begin
            lat = 0;
            while (!rsp_valid && lat < 50) begin
                @(negedge clk);
                lat++;
            end
            check(lat == E_LAT, "R6 read latency", 32'(lat), 32'(E_LAT));
            m = {{8{be[1]}}, {8{be[0]}}};
            check(rsp_data == (shadow[a[7:0]] & m), "R7 read data with lane mask",
                  32'(rsp_data), 32'(shadow[a[7:0]] & m));
            k = 0;
            @(negedge clk);
            k++;
            check(!rsp_valid, "R6 single-cycle strobe", 32'(rsp_valid), 32'd0);
            while (!req_ready && k < 50) begin
                @(negedge clk);
                k++;
            end
            check(k == E_TA, "R8 ready after release", 32'(k), 32'(E_TA));
        end
    endtask

    function automatic logic [17:0] addr_of(input int i);
        return {10'(i * 37 + 3), 8'(i * 5 + 1)};
    endfunction

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("after reset");
        check(!rsp_valid, "R1 no response after reset", 32'(rsp_valid), 32'd0);

        // Full-word fill, then full readback
        for (int i = 0; i < 16; i++) access(1'b1, addr_of(i), 16'(i * 16'h1357) ^ 16'hA0F0, 2'b11);
        for (int i = 0; i < 16; i++) access(1'b0, addr_of(i), 16'h0, 2'b11);

        // Partial overwrites across every lane combination (R4), masked readback (R7)
        for (int i = 0; i < 16; i++) access(1'b1, addr_of(i), ~16'(i * 16'h2461), 2'(i));
        for (int i = 0; i < 16; i++) begin
            access(1'b0, addr_of(i), 16'h0, 2'b11);
            access(1'b0, addr_of(i), 16'h0, 2'(i + 1));
        end

        // Back-to-back turnaround pairs on one address
        for (int i = 0; i < 4; i++) begin
            access(1'b1, addr_of(20 + i), 16'h8001 << i, 2'b11);
            access(1'b0, addr_of(20 + i), 16'h0, 2'b11);
            access(1'b1, addr_of(20 + i), 16'h0FF0 ^ 16'(i), 2'(i));
            access(1'b0, addr_of(20 + i), 16'h0, 2'b11);
        end

        @(negedge clk);
        check_idle("at end");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule